// File: doc/BRIEF.md
# CAN Transmit Buffer Selector

This block sits between a small set of transmit message buffers and the bit-level protocol engine of a CAN controller. Software loads a buffer with an 8-bit local priority, a 4-bit data length code and a remote-frame flag. Loading a buffer marks it pending by clearing its empty flag. When the engine is about to send a start-of-frame bit, it raises a request. The selector then compares every pending buffer and latches the winner. The lowest priority value wins, and a tie goes to the lower index.

The latched grant gives the engine the buffer index, the length code exactly as programmed and the payload byte count. The byte count is zero for a remote frame and is capped at eight for a data frame. The grant holds steady until the engine reports one of two outcomes. On frame done, the buffer is released by setting its empty flag. On lost arbitration, the buffer stays pending and competes again at the next start of frame.

Top module: `can_tx_buf_sel`

## Requirements
- R1: After a synchronous reset, every empty flag reads 1 (`buf_empty` all ones) and `sel_valid` is 0.
- R2: A cycle with `wr_en` high stores priority, length code and remote flag into buffer `wr_idx` and clears its empty flag on the next clock edge.
- R3: On a start-of-frame request, the pending buffer with the smallest priority value is granted.
- R4: Buffers whose empty flag is 1 never take part. A request with no pending buffer leaves `sel_valid` at 0.
- R5: When pending buffers share the smallest priority value, the lowest index is granted.
- R6: For a data frame (remote flag 0), `sel_dlc` equals the stored code and `sel_bytes` equals it for codes 0 to 8.
- R7: For a data frame with code 9 to 15, `sel_bytes` is 8.
- R8: For a remote frame (remote flag 1), `sel_bytes` is 0 and `sel_dlc` still carries the stored code.
- R9: While `sel_valid` is 1 and neither `frame_done` nor `arb_lost` is high, index, code and byte count stay unchanged. This holds even if buffers are written or further requests arrive.
- R10: `frame_done` while granted sets the empty flag of the granted buffer and clears `sel_valid` on the next edge. `frame_done` takes precedence over `arb_lost`.
- R11: `arb_lost` while granted clears `sel_valid` and leaves the buffer's empty flag at 0, so it can win again at the next request.
- R12: Grant outputs are registered. They change on the clock edge that samples `sof_req`, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load a buffer and mark it pending |
| wr_idx | input | IDX_W (2) | Buffer being loaded |
| wr_prio | input | PRIO_W (8) | Local priority; smaller is more urgent |
| wr_dlc | input | 4 | Data length code |
| wr_rtr | input | 1 | 1 = remote frame |
| sof_req | input | 1 | Engine is about to send start of frame |
| frame_done | input | 1 | Granted frame completed |
| arb_lost | input | 1 | Granted frame lost bus arbitration |
| sel_valid | output | 1 | A buffer is granted |
| sel_idx | output | IDX_W (2) | Granted buffer index |
| sel_dlc | output | 4 | Granted length code, as programmed |
| sel_bytes | output | 4 | Payload byte count of the granted frame |
| buf_empty | output | NUM_BUFS (3) | Per-buffer empty flags |

## Verification
The checks assume that the engine reports `frame_done` or `arb_lost` only while a grant is held. They also assume that software does not reload the buffer being released in the same cycle as its `frame_done`. Release checks exclude that collision explicitly. The hold property also assumes that the engine keeps the grant until it reports an outcome. The stimulus keeps to these rules: the bench pulses an outcome only after it has seen a grant, and it writes only to other buffers or to already pending buffers while a grant is held.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;

  localparam int DLC_W     = 4;
  localparam int BYTE_W    = 4;
  localparam int MAX_BYTES = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sel_state_e;

  // Payload size implied by a length code and the frame kind.
  function automatic logic [BYTE_W-1:0] payload_bytes(input logic [DLC_W-1:0] code,
                                                      input logic             remote);
    logic [BYTE_W-1:0] n;
    if (remote)                       n = '0;
    else if (32'(code) > MAX_BYTES)   n = BYTE_W'(MAX_BYTES);
    else                              n = BYTE_W'(code);
    return n;
  endfunction

endpackage

// File: rtl/can_txsel_bank.sv
module can_txsel_bank
  import can_txsel_pkg::*;
#(
  parameter int NUM_BUFS = 3,
  parameter int PRIO_W   = 8,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [PRIO_W-1:0]   wr_prio,
  input  logic [DLC_W-1:0]    wr_dlc,
  input  logic                wr_rtr,
  input  logic [NUM_BUFS-1:0] release_i,
  output logic [NUM_BUFS-1:0] empty_o,
  output logic [PRIO_W-1:0]   prio_o [NUM_BUFS],
  output logic [DLC_W-1:0]    dlc_o  [NUM_BUFS],
  output logic                rtr_o  [NUM_BUFS]
);

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic hit;
    assign hit = wr_en && (32'(wr_idx) == b);

    // Contents: plain storage, no reset needed (guarded by the empty flag).
    always_ff @(posedge clk) begin
      if (hit) begin
        prio_o[b] <= wr_prio;
        dlc_o[b]  <= wr_dlc;
        rtr_o[b]  <= wr_rtr;
      end
    end

    // Empty flag: a fresh load wins over a same-cycle release.
    always_ff @(posedge clk) begin
      if (rst)             empty_o[b] <= 1'b1;
      else if (hit)        empty_o[b] <= 1'b0;
      else if (release_i[b]) empty_o[b] <= 1'b1;
    end
  end

endmodule

// File: rtl/can_txsel_arbiter.sv
module can_txsel_arbiter #(
  parameter int NUM_BUFS = 3,
  parameter int PRIO_W   = 8,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic [NUM_BUFS-1:0] pending_i,
  input  logic [PRIO_W-1:0]   prio_i [NUM_BUFS],
  output logic                any_o,
  output logic [IDX_W-1:0]    win_o
);

  // Ascending scan with strict less-than: ties keep the lower index.
  always_comb begin
    logic [PRIO_W-1:0] best;
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int b = 0; b < NUM_BUFS; b++) begin
      if (pending_i[b] && (!any_o || prio_i[b] < best)) begin
        any_o = 1'b1;
        win_o = IDX_W'(b);
        best  = prio_i[b];
      end
    end
  end

endmodule

// File: rtl/can_txsel_grant.sv
module can_txsel_grant
  import can_txsel_pkg::*;
#(
  parameter int NUM_BUFS = 3,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sof_req,
  input  logic                frame_done,
  input  logic                arb_lost,
  input  logic                any_i,
  input  logic [IDX_W-1:0]    win_i,
  input  logic [DLC_W-1:0]    dlc_i [NUM_BUFS],
  input  logic                rtr_i [NUM_BUFS],
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [DLC_W-1:0]    dlc_o,
  output logic [BYTE_W-1:0]   bytes_o,
  output logic [NUM_BUFS-1:0] release_o
);

  sel_state_e state;

  assign valid_o = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx_o   <= '0;
      dlc_o   <= '0;
      bytes_o <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (sof_req && any_i) begin
          state   <= ST_BUSY;
          idx_o   <= win_i;
          dlc_o   <= dlc_i[win_i];
          bytes_o <= payload_bytes(dlc_i[win_i], rtr_i[win_i]);
        end
        ST_BUSY: if (frame_done || arb_lost) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_rel
    assign release_o[b] = (state == ST_BUSY) && frame_done && (32'(idx_o) == b);
  end

endmodule

// File: rtl/can_tx_buf_sel.sv
module can_tx_buf_sel
  import can_txsel_pkg::*;
#(
  parameter int NUM_BUFS = 3,
  parameter int PRIO_W   = 8,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [PRIO_W-1:0]   wr_prio,
  input  logic [DLC_W-1:0]    wr_dlc,
  input  logic                wr_rtr,
  input  logic                sof_req,
  input  logic                frame_done,
  input  logic                arb_lost,
  output logic                sel_valid,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [DLC_W-1:0]    sel_dlc,
  output logic [BYTE_W-1:0]   sel_bytes,
  output logic [NUM_BUFS-1:0] buf_empty
);

  logic [PRIO_W-1:0]   prio [NUM_BUFS];
  logic [DLC_W-1:0]    dlc  [NUM_BUFS];
  logic                rtr  [NUM_BUFS];
  logic [NUM_BUFS-1:0] release_v;
  logic                any_pending;
  logic [IDX_W-1:0]    win;

  can_txsel_bank #(.NUM_BUFS(NUM_BUFS), .PRIO_W(PRIO_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_prio(wr_prio), .wr_dlc(wr_dlc), .wr_rtr(wr_rtr),
    .release_i(release_v),
    .empty_o(buf_empty), .prio_o(prio), .dlc_o(dlc), .rtr_o(rtr)
  );

  can_txsel_arbiter #(.NUM_BUFS(NUM_BUFS), .PRIO_W(PRIO_W)) u_arb (
    .pending_i(~buf_empty), .prio_i(prio), .any_o(any_pending), .win_o(win)
  );

  can_txsel_grant #(.NUM_BUFS(NUM_BUFS)) u_grant (
    .clk(clk), .rst(rst),
    .sof_req(sof_req), .frame_done(frame_done), .arb_lost(arb_lost),
    .any_i(any_pending), .win_i(win), .dlc_i(dlc), .rtr_i(rtr),
    .valid_o(sel_valid), .idx_o(sel_idx), .dlc_o(sel_dlc), .bytes_o(sel_bytes),
    .release_o(release_v)
  );

endmodule

// File: rtl/can_tx_buf_sel_chk.sv
module can_tx_buf_sel_chk #(
  parameter int NUM_BUFS = 3,
  parameter int PRIO_W   = 8,
  localparam int IDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [PRIO_W-1:0]   wr_prio,
  input logic [3:0]          wr_dlc,
  input logic                wr_rtr,
  input logic                sof_req,
  input logic                frame_done,
  input logic                arb_lost,
  input logic                sel_valid,
  input logic [IDX_W-1:0]    sel_idx,
  input logic [3:0]          sel_dlc,
  input logic [3:0]          sel_bytes,
  input logic [NUM_BUFS-1:0] buf_empty
);

  logic [NUM_BUFS-1:0] sel_oh;
  assign sel_oh = NUM_BUFS'(1) << sel_idx;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (&buf_empty && !sel_valid)); // R1

  AST_WRITE_PENDING: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((buf_empty & $past(NUM_BUFS'(1) << wr_idx)) == '0)); // R2

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) |-> ((buf_empty & sel_oh) == '0)); // R4

  AST_NO_GRANT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && sof_req && &buf_empty && !wr_en) |=> !sel_valid); // R4

  AST_BYTES_CAP: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_bytes <= 4'd8)); // R7

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !frame_done && !arb_lost) |=>
      (sel_valid && $stable(sel_idx) && $stable(sel_dlc) && $stable(sel_bytes))); // R9

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && frame_done && !(wr_en && wr_idx == sel_idx)) |=>
      (!sel_valid && ((buf_empty & $past(sel_oh)) == $past(sel_oh)))); // R10

  AST_LOST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && arb_lost && !frame_done) |=>
      (!sel_valid && ((buf_empty & $past(sel_oh)) == '0))); // R11

  AST_GRANT_AFTER_SOF: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) |-> $past(sof_req)); // R12

endmodule

bind can_tx_buf_sel can_tx_buf_sel_chk #(.NUM_BUFS(NUM_BUFS), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/tb_can_tx_buf_sel.sv
`timescale 1ns/1ps
module tb_can_tx_buf_sel;

  localparam int N = 3;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [PW-1:0] wr_prio = '0;
  logic [3:0] wr_dlc = '0;
  logic wr_rtr = 1'b0;
  logic sof_req = 1'b0, frame_done = 1'b0, arb_lost = 1'b0;
  logic sel_valid;
  logic [1:0] sel_idx;
  logic [3:0] sel_dlc, sel_bytes;
  logic [N-1:0] buf_empty;

  always #2 clk = ~clk;

  can_tx_buf_sel #(.NUM_BUFS(N), .PRIO_W(PW)) dut (.*);

  typedef struct { bit valid; int idx; int dlc; int bytes; string req; } exp_t;
  exp_t q[$];
  exp_t cur;
  bit armed = 0;
  int checks = 0, errors = 0;

  // Bench model of the buffers, built from the requirements.
  bit m_empty[N];
  int m_prio[N], m_dlc[N];
  bit m_rtr[N];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_bytes(int d, bit r);
    if (r) return 0;
    return (d > 8) ? 8 : d;
  endfunction

  function automatic int model_empty();
    int v = 0;
    for (int b = 0; b < N; b++) v |= int'(m_empty[b]) << b;
    return v;
  endfunction

  function automatic exp_t predict(string req);
    exp_t e;
    e.valid = 0; e.idx = 0; e.dlc = 0; e.bytes = 0; e.req = req;
    for (int b = 0; b < N; b++)
      if (!m_empty[b] && (!e.valid || m_prio[b] < m_prio[e.idx])) begin
        e.valid = 1; e.idx = b;
      end
    if (e.valid) begin
      e.dlc = m_dlc[e.idx];
      e.bytes = model_bytes(m_dlc[e.idx], m_rtr[e.idx]);
    end
    return e;
  endfunction

  // Monitor: 1 ns after the edge that sampled the request.
  always @(posedge clk) begin
    #1;
    if (armed) begin
      exp_t e;
      armed = 0;
      e = q.pop_front();
      chk({e.req, " R12 valid"}, int'(sel_valid), int'(e.valid));
      if (e.valid) begin
        chk({e.req, " idx"}, int'(sel_idx), e.idx);
        chk({e.req, " dlc"}, int'(sel_dlc), e.dlc);
        chk({e.req, " bytes"}, int'(sel_bytes), e.bytes);
      end
      cur = e;
    end
  end

  task automatic load(int idx, int prio, int dlc, bit rtr);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(idx); wr_prio = PW'(prio); wr_dlc = 4'(dlc); wr_rtr = rtr;
    @(negedge clk);
    wr_en = 0;
    m_empty[idx] = 0; m_prio[idx] = prio; m_dlc[idx] = dlc; m_rtr[idx] = rtr;
  endtask

  task automatic do_sof(string req);
    q.push_back(predict(req));
    @(negedge clk);
    sof_req = 1; armed = 1;
    #0.5 chk("R12 no early grant", int'(sel_valid), 0);
    @(negedge clk);
    sof_req = 0;
  endtask

  task automatic hold_check(string req);
    chk({req, " R9 valid"}, int'(sel_valid), 1);
    chk({req, " R9 idx"}, int'(sel_idx), cur.idx);
    chk({req, " R9 dlc"}, int'(sel_dlc), cur.dlc);
    chk({req, " R9 bytes"}, int'(sel_bytes), cur.bytes);
  endtask

  task automatic finish_done(string req);
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    m_empty[cur.idx] = 1;
    chk({req, " R10 empty"}, int'(buf_empty), model_empty());
    chk({req, " R10 valid"}, int'(sel_valid), 0);
  endtask

  task automatic lose(string req);
    @(negedge clk); arb_lost = 1;
    @(negedge clk); arb_lost = 0;
    chk({req, " R11 empty"}, int'(buf_empty), model_empty());
    chk({req, " R11 valid"}, int'(sel_valid), 0);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    for (int b = 0; b < N; b++) begin m_empty[b] = 1; m_prio[b] = 0; m_dlc[b] = 0; m_rtr[b] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 empty", int'(buf_empty), 7);
    chk("R1 valid", int'(sel_valid), 0);

    do_sof("R4 none pending");

    load(0, 20, 3, 0);
    load(1, 5, 8, 0);
    load(2, 9, 12, 0);
    chk("R2 flags", int'(buf_empty), 0);
    do_sof("R3 R6 lowest prio");
    @(negedge clk);
    // Writes and a second request while granted must not disturb the grant.
    load(2, 0, 12, 0);
    @(negedge clk); sof_req = 1;
    @(negedge clk); sof_req = 0;
    hold_check("hold");
    finish_done("b1 done");

    do_sof("R7 clamp 12");
    lose("b2 lost");
    do_sof("R11 competes again");
    finish_done("b2 done");

    load(1, 20, 5, 1);
    do_sof("R5 tie lower index");
    finish_done("b0 done");
    do_sof("R8 remote");
    finish_done("b1 remote done");
    do_sof("R4 all empty");

    for (int d = 0; d < 16; d++) begin
      load(0, d, d, 0);
      do_sof((d > 8) ? "R7 sweep" : "R6 sweep");
      finish_done("sweep done");
    end
    load(2, 3, 15, 1);
    do_sof("R8 remote code 15");
    finish_done("R8 done");

    repeat (2) @(negedge clk);
    report();
  end

endmodule